// File: doc/BRIEF.md
# Fault and Interrupt Arbitration Unit

This unit settles, in one decision, how a processor responds when hardware faults and interrupts show up at the same instruction boundary. Each request carries a set of fault flags, a set of instruction-interrupt causes, the pending condition interrupts with two mask values, a kernel-mode flag, the addresses of the current and next instruction, a kernel request code and a lock entry pointer. From these it picks one of four responses: no action, a hardware call procedure, an interrupt procedure, or both in that order. A fault raised while in kernel mode halts the processor instead.

A fixed algorithm governs the decision. An instruction interrupt is thrown away when an instruction-related fault is present. A lone trace fault is thrown away when it comes with a failed lock. Whatever fault remains forces a hardware call. The interrupt procedure is then taken if an instruction interrupt survives, or if a pending condition is enabled by the mask that applies after the hardware call. Along with the decision the unit produces the interrupt cause code, the 32-bit cause word, the cause-extension word and the return address to save for each procedure.

Requests enter through a valid/ready handshake. A request is taken on any clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` stays high unless the unit has halted, so a halt is the only source of back-pressure. Taken requests can follow one another on every cycle. The result is a registered, one-cycle strobe with no back-pressure of its own. The consumer must act on it in the cycle it appears.

Top module: `fault_intr_arbiter`

## Requirements
- R1: A request is taken when `in_valid_i` and `in_ready_o` are high at a clock edge. Exactly one cycle later `dec_valid_o` is high for one cycle with that request's result. Back-to-back requests give back-to-back strobes.
- R2: Fault bits 0 to 4 are instruction-related: address error, invalid instruction, invalid arithmetic data, instruction timeout and uncorrectable memory error. When any of them is set, all instruction-interrupt causes of that request are discarded.
- R3: When cause bit 0 (failed lock) is set and the fault vector holds only bit 8 (trace), the trace fault is discarded and no hardware call results.
- R4: Any fault bit left after R2 and R3 raises `act_hcp_o`, provided `kernel_i` is low.
- R5: A remaining fault with `kernel_i` high raises `act_halt_o` and no other action. `halt_faults_o` records the remaining fault bits and `halted_o` goes high. Both hold, with `in_ready_o` low, until reset.
- R6: `act_intr_o` is high when the unit is not halting and either a cause survives R2 or `cond_pend_i` ANDed with the effective mask is nonzero. The effective mask is `mask_hcp_i` when a hardware call is taken, and `mask_now_i` otherwise.
- R7: With a hardware call, `hcp_ret_addr_o` is `cur_addr_i` if any remaining fault is in bits 0 to 7 (bits 5 to 7 being alter-table entry, accumulator trap and current-address memory-area fault). Otherwise it is `next_addr_i` (bit 8 trace, bit 9 soft fault, bit 10 next-address memory-area fault). It is zero without a hardware call.
- R8: With an interrupt procedure, `intr_ret_addr_o` is `cur_addr_i` when the cause code is 7 (failed branch-reinstate). Otherwise it is `next_addr_i`. It is zero without an interrupt procedure.
- R9: Cause bit k maps to code k+1: 1 failed lock, 2 failed event, 3 released lock, 4 released event, 5 failed hardware call, 6 kernel request, 7 failed branch-reinstate. The lowest set surviving bit wins. The code is 0 when no cause survives or no interrupt procedure is taken.
- R10: `cause_word_o` is {8'hC1, 8'h00, code, 8'h00} for a nonzero code, and zero otherwise.
- R11: For code 6, `ext_word_o` is {20'hC1000, kreq_code_i, 4'h0}. For codes 1 to 4 it is {8'hC7, lock_ptr_i}. For either case `ext_valid_o` is high. For any other code both are zero.
- R12: After reset every output is zero except `in_ready_o`, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request ready (low once halted) |
| fault_i | input | 11 | Hardware fault flags, bit map in R2/R7 |
| ii_cause_i | input | 7 | Instruction-interrupt causes, bit k = code k+1 |
| cond_pend_i | input | CND_W | Pending condition interrupts |
| mask_now_i | input | CND_W | Condition mask in force now |
| mask_hcp_i | input | CND_W | Condition mask loaded by a hardware call |
| kernel_i | input | 1 | Processor is in kernel mode |
| cur_addr_i | input | ADDR_W | Address of the current instruction |
| next_addr_i | input | ADDR_W | Address of the next instruction |
| kreq_code_i | input | 8 | Kernel request code |
| lock_ptr_i | input | 24 | Linked task entry pointer for lock causes |
| dec_valid_o | output | 1 | Decision strobe |
| act_hcp_o | output | 1 | Perform hardware call procedure |
| act_intr_o | output | 1 | Perform interrupt procedure |
| act_halt_o | output | 1 | Halt the processor |
| halted_o | output | 1 | Sticky halted state |
| halt_faults_o | output | 11 | Fault bits recorded at halt |
| cause_code_o | output | 8 | Instruction-interrupt cause code |
| cause_word_o | output | 32 | Cause word |
| ext_valid_o | output | 1 | Extension word present |
| ext_word_o | output | 32 | Cause-extension word |
| hcp_ret_addr_o | output | ADDR_W | Address saved by the hardware call |
| intr_ret_addr_o | output | ADDR_W | Address saved by the interrupt procedure |

## Verification
The assertions assume that a strobe is only read in the cycle after an accepted request. The request inputs are sampled solely at acceptance, so values driven while `in_valid_i` is low must not affect any check. The bench changes inputs only at falling edges and holds `in_valid_i` low during reset. It keeps `kernel_i` low with faults present everywhere except the final halt case, and after that case it resets before checking anything else. Its stimulus covers every suppression rule, both mask sources, each address class and priority between simultaneous causes.

// File: rtl/fia_pkg.sv
package fia_pkg;
  localparam int FLT_W   = 11;
  localparam int II_W    = 7;
  localparam int PTR_W   = 24;
  localparam int KRQ_W   = 8;
  localparam int CODE_W  = 8;
  localparam int WORD_W  = 32;

  // fault bit positions
  localparam int F_ADDR_ERR   = 0;
  localparam int F_BAD_INSTR  = 1;
  localparam int F_BAD_ARITH  = 2;
  localparam int F_TIMEOUT    = 3;
  localparam int F_MEM_UNCORR = 4;
  localparam int F_ALT_TABLE  = 5;
  localparam int F_ACC_TRAP   = 6;
  localparam int F_AREA_CUR   = 7;
  localparam int F_TRACE      = 8;
  localparam int F_SOFT       = 9;
  localparam int F_AREA_NEXT  = 10;

  // instruction-related faults suppress instruction interrupts
  localparam logic [FLT_W-1:0] INSTR_FLT_MASK =
    (FLT_W'(1) << F_ADDR_ERR) | (FLT_W'(1) << F_BAD_INSTR) |
    (FLT_W'(1) << F_BAD_ARITH) | (FLT_W'(1) << F_TIMEOUT) |
    (FLT_W'(1) << F_MEM_UNCORR);

  // faults that save the failing instruction address
  localparam logic [FLT_W-1:0] CUR_ADDR_MASK =
    INSTR_FLT_MASK | (FLT_W'(1) << F_ALT_TABLE) |
    (FLT_W'(1) << F_ACC_TRAP) | (FLT_W'(1) << F_AREA_CUR);

  localparam logic [FLT_W-1:0] TRACE_ONLY = FLT_W'(1) << F_TRACE;

  // cause bit positions (code = bit + 1)
  localparam int C_FAIL_LOCK = 0;
  localparam logic [CODE_W-1:0] CODE_KREQ     = 8'd6;
  localparam logic [CODE_W-1:0] CODE_BRV_FAIL = 8'd7;
  localparam logic [CODE_W-1:0] CODE_LOCK_MAX = 8'd4;

  localparam logic [7:0]  CW_HEAD  = 8'hC1;
  localparam logic [7:0]  EXT_LOCK = 8'hC7;
  localparam logic [19:0] EXT_KREQ = 20'hC1000;
endpackage

// File: rtl/fia_resolve.sv
module fia_resolve
  import fia_pkg::*;
#(
  parameter int CND_W = 4
) (
  input  logic [FLT_W-1:0] fault_i,
  input  logic [II_W-1:0]  ii_i,
  input  logic [CND_W-1:0] cond_i,
  input  logic [CND_W-1:0] mask_now_i,
  input  logic [CND_W-1:0] mask_hcp_i,
  input  logic             kernel_i,
  output logic [FLT_W-1:0] fault_eff_o,
  output logic [II_W-1:0]  ii_eff_o,
  output logic             do_hcp_o,
  output logic             do_halt_o,
  output logic             do_intr_o
);
  logic             instr_flt;
  logic             lone_trace;
  logic             hcp_req;
  logic [CND_W-1:0] mask_eff;

  always_comb begin
    // step 1: a faulty instruction did not really complete
    instr_flt   = |(fault_i & INSTR_FLT_MASK);
    ii_eff_o    = instr_flt ? '0 : ii_i;
    // step 2: failed lock swallows a lone trace
    lone_trace  = ii_i[C_FAIL_LOCK] && (fault_i == TRACE_ONLY);
    fault_eff_o = lone_trace ? '0 : fault_i;
    // step 3: remaining faults call, or halt in kernel mode
    hcp_req     = |fault_eff_o;
    do_halt_o   = hcp_req && kernel_i;
    do_hcp_o    = hcp_req && !kernel_i;
    // step 4: mask may have been reloaded by the call
    mask_eff    = do_hcp_o ? mask_hcp_i : mask_now_i;
    do_intr_o   = !do_halt_o && ((|ii_eff_o) || (|(cond_i & mask_eff)));
  end
endmodule

// File: rtl/fia_cause_enc.sv
module fia_cause_enc
  import fia_pkg::*;
(
  input  logic [II_W-1:0]   ii_i,
  input  logic              en_i,
  input  logic [KRQ_W-1:0]  kreq_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [CODE_W-1:0] code_o,
  output logic [WORD_W-1:0] word_o,
  output logic              ext_valid_o,
  output logic [WORD_W-1:0] ext_word_o
);
  logic [CODE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int b = II_W - 1; b >= 0; b--) begin
      if (ii_i[b]) pick = CODE_W'(b + 1);
    end
    code_o      = en_i ? pick : '0;
    word_o      = (code_o != '0) ? {CW_HEAD, 8'h00, code_o, 8'h00} : '0;
    ext_valid_o = 1'b0;
    ext_word_o  = '0;
    if (code_o == CODE_KREQ) begin
      ext_valid_o = 1'b1;
      ext_word_o  = {EXT_KREQ, kreq_i, 4'h0};
    end else if (code_o != '0 && code_o <= CODE_LOCK_MAX) begin
      ext_valid_o = 1'b1;
      ext_word_o  = {EXT_LOCK, ptr_i};
    end
  end
endmodule

// File: rtl/fia_ret_sel.sv
module fia_ret_sel
  import fia_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [FLT_W-1:0]  fault_eff_i,
  input  logic              do_hcp_i,
  input  logic              do_intr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] next_i,
  output logic [ADDR_W-1:0] hcp_addr_o,
  output logic [ADDR_W-1:0] intr_addr_o
);
  logic cur_class;

  always_comb begin
    cur_class   = |(fault_eff_i & CUR_ADDR_MASK);
    hcp_addr_o  = !do_hcp_i ? '0 : (cur_class ? cur_i : next_i);
    intr_addr_o = !do_intr_i ? '0 :
                  ((code_i == CODE_BRV_FAIL) ? cur_i : next_i);
  end
endmodule

// File: rtl/fault_intr_arbiter.sv
module fault_intr_arbiter
  import fia_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CND_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [10:0]       fault_i,
  input  logic [6:0]        ii_cause_i,
  input  logic [CND_W-1:0]  cond_pend_i,
  input  logic [CND_W-1:0]  mask_now_i,
  input  logic [CND_W-1:0]  mask_hcp_i,
  input  logic              kernel_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic [7:0]        kreq_code_i,
  input  logic [23:0]       lock_ptr_i,
  output logic              dec_valid_o,
  output logic              act_hcp_o,
  output logic              act_intr_o,
  output logic              act_halt_o,
  output logic              halted_o,
  output logic [10:0]       halt_faults_o,
  output logic [7:0]        cause_code_o,
  output logic [31:0]       cause_word_o,
  output logic              ext_valid_o,
  output logic [31:0]       ext_word_o,
  output logic [ADDR_W-1:0] hcp_ret_addr_o,
  output logic [ADDR_W-1:0] intr_ret_addr_o
);
  logic [FLT_W-1:0]  fault_eff;
  logic [II_W-1:0]   ii_eff;
  logic              do_hcp, do_halt, do_intr;
  logic [CODE_W-1:0] code;
  logic [WORD_W-1:0] cword, eword;
  logic              evalid;
  logic [ADDR_W-1:0] haddr, iaddr;
  logic              take;
  logic              past_ok;

  assign in_ready_o = !halted_o;
  assign take       = in_valid_i && in_ready_o;

  fia_resolve #(.CND_W(CND_W)) u_resolve (
    .fault_i    (fault_i),
    .ii_i       (ii_cause_i),
    .cond_i     (cond_pend_i),
    .mask_now_i (mask_now_i),
    .mask_hcp_i (mask_hcp_i),
    .kernel_i   (kernel_i),
    .fault_eff_o(fault_eff),
    .ii_eff_o   (ii_eff),
    .do_hcp_o   (do_hcp),
    .do_halt_o  (do_halt),
    .do_intr_o  (do_intr)
  );

  fia_cause_enc u_cause (
    .ii_i       (ii_eff),
    .en_i       (do_intr),
    .kreq_i     (kreq_code_i),
    .ptr_i      (lock_ptr_i),
    .code_o     (code),
    .word_o     (cword),
    .ext_valid_o(evalid),
    .ext_word_o (eword)
  );

  fia_ret_sel #(.ADDR_W(ADDR_W)) u_ret (
    .fault_eff_i(fault_eff),
    .do_hcp_i   (do_hcp),
    .do_intr_i  (do_intr),
    .code_i     (code),
    .cur_i      (cur_addr_i),
    .next_i     (next_addr_i),
    .hcp_addr_o (haddr),
    .intr_addr_o(iaddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid_o     <= 1'b0;
      act_hcp_o       <= 1'b0;
      act_intr_o      <= 1'b0;
      act_halt_o      <= 1'b0;
      halted_o        <= 1'b0;
      halt_faults_o   <= '0;
      cause_code_o    <= '0;
      cause_word_o    <= '0;
      ext_valid_o     <= 1'b0;
      ext_word_o      <= '0;
      hcp_ret_addr_o  <= '0;
      intr_ret_addr_o <= '0;
      past_ok         <= 1'b0;
    end else begin
      past_ok         <= 1'b1;
      dec_valid_o     <= take;
      act_hcp_o       <= take && do_hcp;
      act_intr_o      <= take && do_intr;
      act_halt_o      <= take && do_halt;
      cause_code_o    <= take ? code   : '0;
      cause_word_o    <= take ? cword  : '0;
      ext_valid_o     <= take && evalid;
      ext_word_o      <= take ? eword  : '0;
      hcp_ret_addr_o  <= take ? haddr  : '0;
      intr_ret_addr_o <= take ? iaddr  : '0;
      if (take && do_halt) begin
        halted_o      <= 1'b1;
        halt_faults_o <= fault_eff;
      end
    end
  end

  // R5: once halted, stays halted and refuses input
  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o && !in_ready_o);

  // R5: a halt excludes both procedures
  a_r5_halt_alone: assert property (@(posedge clk) disable iff (!rst_n)
    act_halt_o |-> !act_hcp_o && !act_intr_o && halted_o);

  // R1: nothing is reported without a strobe
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_o |-> !act_hcp_o && !act_intr_o && !act_halt_o && !ext_valid_o);

  // R2: instruction-related fault leaves no cause code
  a_r2_cause_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && dec_valid_o && $past(|(fault_i & INSTR_FLT_MASK)) |-> cause_code_o == '0);

  // R3: failed lock with lone trace gives no call
  a_r3_trace_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && dec_valid_o && $past(ii_cause_i[0] && fault_i == TRACE_ONLY)
    |-> !act_hcp_o && !act_halt_o && act_intr_o);

  // R7: current-address fault class saves the current address
  a_r7_cur_addr: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && act_hcp_o && $past(|(fault_i & CUR_ADDR_MASK))
    |-> hcp_ret_addr_o == $past(cur_addr_i));

  // R9/R10: code range and word header
  a_r9_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    cause_code_o <= CODE_BRV_FAIL && (cause_code_o == '0 || act_intr_o));
  a_r10_word_head: assert property (@(posedge clk) disable iff (!rst_n)
    cause_code_o != '0 |-> cause_word_o[31:24] == CW_HEAD);
endmodule

// File: tb/sim_fault_intr_arbiter.sv
module sim_fault_intr_arbiter;
  localparam int AW = 32;
  localparam int CW = 4;

  typedef struct {
    string       tag;
    logic        hcp, intr, halt;
    logic [7:0]  code;
    logic [31:0] word, ext;
    logic        ext_v;
    logic [31:0] haddr, iaddr;
    logic [10:0] hflt;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [10:0] fault = '0;
  logic [6:0]  iic = '0;
  logic [CW-1:0] cpend = '0, mnow = '0, mhcp = '0;
  logic kern = 1'b0;
  logic [AW-1:0] cur = '0, nxt = '0;
  logic [7:0]  kreq = '0;
  logic [23:0] lptr = '0;
  logic dv, a_hcp, a_intr, a_halt, halted, e_v;
  logic [10:0] hflt;
  logic [7:0]  code;
  logic [31:0] cword, eword;
  logic [AW-1:0] haddr, iaddr;

  int n_chk = 0;
  int n_bad = 0;
  int stray = 0;
  logic [10:0] last_halt = '0;
  exp_t sbq[$];

  always #2 clk = ~clk;

  fault_intr_arbiter #(.ADDR_W(AW), .CND_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .fault_i(fault), .ii_cause_i(iic), .cond_pend_i(cpend),
    .mask_now_i(mnow), .mask_hcp_i(mhcp), .kernel_i(kern),
    .cur_addr_i(cur), .next_addr_i(nxt), .kreq_code_i(kreq), .lock_ptr_i(lptr),
    .dec_valid_o(dv), .act_hcp_o(a_hcp), .act_intr_o(a_intr), .act_halt_o(a_halt),
    .halted_o(halted), .halt_faults_o(hflt), .cause_code_o(code),
    .cause_word_o(cword), .ext_valid_o(e_v), .ext_word_o(eword),
    .hcp_ret_addr_o(haddr), .intr_ret_addr_o(iaddr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
    end
  endtask

  // expected result written from the requirement text
  function automatic exp_t model(input string tag, input logic [10:0] f,
      input logic [6:0] c, input logic [CW-1:0] p, mn, mh, input logic k,
      input logic [31:0] ca, na, input logic [7:0] kr, input logic [23:0] lp);
    exp_t e;
    logic [6:0] keep;
    logic [10:0] rest;
    logic [CW-1:0] m;
    e.tag = tag;
    keep = (f[4:0] != 0) ? 7'd0 : c;                         // R2
    rest = (c[0] && f == 11'h100) ? 11'd0 : f;               // R3
    e.halt = (rest != 0) && k;                               // R5
    e.hcp  = (rest != 0) && !k;                              // R4
    m = e.hcp ? mh : mn;                                     // R6
    e.intr = !e.halt && ((keep != 0) || ((p & m) != 0));
    e.code = 8'd0;                                           // R9
    if (e.intr) begin
      for (int b = 6; b >= 0; b--) if (keep[b]) e.code = 8'(b + 1);
    end
    e.word = (e.code != 0) ? (32'hC1000000 | (32'(e.code) << 8)) : 32'd0;  // R10
    e.ext_v = 1'b0; e.ext = 32'd0;                           // R11
    if (e.code == 8'd6) begin e.ext_v = 1'b1; e.ext = 32'hC1000000 | (32'(kr) << 4); end
    else if (e.code >= 8'd1 && e.code <= 8'd4) begin e.ext_v = 1'b1; e.ext = {8'hC7, lp}; end
    e.haddr = !e.hcp ? 32'd0 : ((rest[7:0] != 0) ? ca : na); // R7
    e.iaddr = !e.intr ? 32'd0 : ((e.code == 8'd7) ? ca : na); // R8
    e.hflt = e.halt ? rest : last_halt;
    return e;
  endfunction

  task automatic send(input string tag, input logic [10:0] f, input logic [6:0] c,
      input logic [CW-1:0] p, mn, mh, input logic k,
      input logic [31:0] ca, na, input logic [7:0] kr, input logic [23:0] lp);
    exp_t e;
    @(negedge clk);
    e = model(tag, f, c, p, mn, mh, k, ca, na, kr, lp);
    if (e.halt) last_halt = e.hflt;
    sbq.push_back(e);
    fault = f; iic = c; cpend = p; mnow = mn; mhcp = mh; kern = k;
    cur = ca; nxt = na; kreq = kr; lptr = lp; in_valid = 1'b1;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; fault = '0; iic = '0; kern = 1'b0;
  endtask

  // monitor: pop and compare on each strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dv) begin
        if (sbq.size() == 0) begin
          stray++;
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(e.tag, "hcp",   32'(a_hcp),  32'(e.hcp));
          chk(e.tag, "intr",  32'(a_intr), 32'(e.intr));
          chk(e.tag, "halt",  32'(a_halt), 32'(e.halt));
          chk(e.tag, "code",  32'(code),   32'(e.code));
          chk(e.tag, "word",  cword,       e.word);
          chk(e.tag, "ext_v", 32'(e_v),    32'(e.ext_v));
          chk(e.tag, "ext",   eword,       e.ext);
          chk(e.tag, "haddr", haddr,       e.haddr);
          chk(e.tag, "iaddr", iaddr,       e.iaddr);
          chk(e.tag, "hflt",  32'(hflt),   32'(e.hflt));
        end
      end
    end
  end

  task automatic reset_check(input string tag);
    chk(tag, "R12 ready", 32'(in_ready), 32'd1);
    chk(tag, "R12 dv", 32'(dv), 32'd0);
    chk(tag, "R12 halted", 32'(halted), 32'd0);
    chk(tag, "R12 hflt", 32'(hflt), 32'd0);
    chk(tag, "R12 word", cword, 32'd0);
    chk(tag, "R12 addr", haddr | iaddr, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    reset_check("R12 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    reset_check("R12 after reset");

    send("R1 empty request", 11'h000, 7'h00, 4'h0, 4'h0, 4'h0, 0, 32'h100, 32'h104, 8'h00, 24'h0);
    idle();
    send("R11 kernel request", 11'h000, 7'h20, 4'h0, 4'h0, 4'h0, 0, 32'h200, 32'h204, 8'h3A, 24'h0);
    send("R11 failed lock ext", 11'h000, 7'h01, 4'h0, 4'h0, 4'h0, 0, 32'h300, 32'h304, 8'h00, 24'hABCDEF);
    send("R9 priority 3 over 7", 11'h000, 7'h44, 4'h0, 4'h0, 4'h0, 0, 32'h400, 32'h404, 8'h00, 24'h123456);
    send("R8 failed branch-reinstate", 11'h000, 7'h40, 4'h0, 4'h0, 4'h0, 0, 32'h500, 32'h504, 8'h00, 24'h0);
    send("R2 bad instr drops kreq", 11'h002, 7'h20, 4'h0, 4'h0, 4'h0, 0, 32'h600, 32'h604, 8'h11, 24'h0);
    send("R3 lock eats trace", 11'h100, 7'h01, 4'h0, 4'h0, 4'h0, 0, 32'h700, 32'h704, 8'h00, 24'h00BEEF);
    send("R4 event keeps trace", 11'h100, 7'h02, 4'h0, 4'h0, 4'h0, 0, 32'h800, 32'h804, 8'h00, 24'h000777);
    send("R7 accum trap wins", 11'h140, 7'h00, 4'h0, 4'h0, 4'h0, 0, 32'h900, 32'h904, 8'h00, 24'h0);
    send("R7 next class", 11'h600, 7'h00, 4'h0, 4'h0, 4'h0, 0, 32'hA00, 32'hA04, 8'h00, 24'h0);
    send("R6 condition enabled", 11'h000, 7'h00, 4'h4, 4'h4, 4'h0, 0, 32'hB00, 32'hB04, 8'h00, 24'h0);
    send("R6 reloaded mask blocks", 11'h200, 7'h00, 4'h4, 4'h4, 4'h0, 0, 32'hC00, 32'hC04, 8'h00, 24'h0);
    send("R6 reloaded mask enables", 11'h200, 7'h00, 4'h4, 4'h0, 4'h4, 0, 32'hD00, 32'hD04, 8'h00, 24'h0);
    send("R9 failed hcp code 5", 11'h000, 7'h10, 4'h0, 4'h0, 4'h0, 0, 32'hE00, 32'hE04, 8'h00, 24'h0);
    send("R5 kernel no fault", 11'h000, 7'h20, 4'h0, 4'h0, 4'h0, 1, 32'hF00, 32'hF04, 8'h55, 24'h0);
    idle();
    send("R5 kernel fault halts", 11'h081, 7'h20, 4'h3, 4'h3, 4'h3, 1, 32'h1000, 32'h1004, 8'h00, 24'h0);
    idle();
    @(negedge clk);
    chk("R5 halted", "halted", 32'(halted), 32'd1);
    chk("R5 ready low", "ready", 32'(in_ready), 32'd0);
    chk("R5 faults kept", "hflt", 32'(hflt), 32'h081);
    in_valid = 1'b1; iic = 7'h20;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 no strobe while halted", "strays", 32'(stray), 32'd0);
    chk("R5 still halted", "halted", 32'(halted), 32'd1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    last_halt = '0;
    @(negedge clk);
    reset_check("R12 restart");
    send("R1 after restart", 11'h008, 7'h00, 4'h0, 4'h0, 4'h0, 0, 32'h2000, 32'h2004, 8'h00, 24'h0);
    idle();
    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", "left", 32'(sbq.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule